// File: doc/BRIEF.md
# Audio Link Reset and Wake Detector

This block sits at the serial-link edge of an audio codec and works out which kind of reset or wake-up the link controller has asked for. Three pins are sampled through two-flop synchronizers on a free-running local reference clock: the active-low reset pin, the frame SYNC input and the incoming bit clock. Reference-clock counters time the pulse widths. The block separates a cold reset, a warm reset and a new-style warm reset. It tells them apart by how long a pin was held, by whether the bit clock was running at that moment, and by whether the link had been placed in its deepest power-down state.

The block drives three results. The first is a full-logic reset level. The second is a one-cycle restart strobe that carries a two-bit event code. The third is a pair of enables: one permits local bit-clock generation, the other lets serial data output resume. Data output comes back only after the bit clock has been seen stable, and only at the next frame start. A control input can switch off new-style warm detection. A strap selects secondary-codec behaviour, in which the return of the bit clock itself counts as the warm reset.

Every duration is a parameter. Durations given in nanoseconds are turned into reference-clock cycle counts by a package function that rounds up. The defaults (a 24.576 MHz reference) give 25 cycles for 1 µs and 5 cycles for the 163 ns restart guard.

Top module: `audlink_reset_classifier`

## Requirements
- R1: When the synchronized reset pin stays low for at least COLD_CYC (default 25) reference cycles, `logic_rst` goes high and stays high while the pin is low. When the pin is released, `logic_rst` drops and `link_restart` pulses with `restart_kind` = 2'b01 (cold). A low pulse shorter than COLD_CYC has no effect on any output.
- R2: In primary mode, SYNC held high for at least WARM_CYC (default 25) cycles while the bit clock is absent, then driven low, produces a `link_restart` pulse with `restart_kind` = 2'b10 (warm). It also clears `link_en` and never raises `logic_rst`.
- R3: A SYNC-high pulse is ignored if the bit clock is running at any point during it, or if it is shorter than WARM_CYC. No strobe follows, and `link_en` stays high.
- R4: After a primary warm reset, `clk_gen_en` is low in the strobe cycle and stays low for at least GUARD_CYC (default 5) cycles once the SYNC fall has been seen.
- R5: A one-cycle `pd_enter` pulse in the running state sets `deep_pd` and clears `link_en` and `clk_gen_en`. While `deep_pd` is high and `nwr_disable` is 0, a low-to-high transition of the reset pin gives `restart_kind` = 2'b11 (new warm) and clears `deep_pd`, whatever the length of the preceding low phase. `logic_rst` is never raised.
- R6: While `deep_pd` is high and `nwr_disable` is 1, a reset-pin low phase of at least COLD_CYC cycles raises `logic_rst`, and the following release reports `restart_kind` = 2'b01.
- R7: With `secondary_mode` = 1, `clk_gen_en` stays 0 and SYNC pulses never cause a warm reset. The first bit-clock rising edge after the clock has been absent (no rising edge for ABSENT_CYC cycles) produces `restart_kind` = 2'b10 and clears `link_en`.
- R8: After any restart, `link_en` rises only on a frame start (SYNC rising edge) seen after at least STABLE_EDGES (default 8) consecutive bit-clock rising edges with no absence between them.
- R9: After power-on reset (`por_n` low), `logic_rst` is high and `link_en` is low until the reset pin is seen high. That release is reported as a cold restart (2'b01).
- R10: `link_restart` never lasts more than one cycle. `restart_kind` is 2'b00 whenever there is no strobe. `logic_rst` and `link_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local reference clock |
| por_n | input | 1 | Active-low power-on reset of the detector itself |
| rst_pin_n | input | 1 | Active-low hardware reset pin from the link controller (asynchronous) |
| sync_in | input | 1 | Frame SYNC pin (asynchronous) |
| bclk_in | input | 1 | Bit clock pin, sampled as data |
| pd_enter | input | 1 | One-cycle pulse: link programmed into deepest power-down |
| nwr_disable | input | 1 | 1 disables new-style warm detection |
| secondary_mode | input | 1 | 1 selects secondary-codec behaviour |
| logic_rst | output | 1 | Full-logic and register reset level |
| link_restart | output | 1 | One-cycle strobe per classified event |
| restart_kind | output | 2 | Event code: 01 cold, 10 warm, 11 new warm, 00 none |
| clk_gen_en | output | 1 | Permission to generate the bit clock (primary mode only) |
| link_en | output | 1 | Enable for serial data output |
| deep_pd | output | 1 | Link is in deepest power-down |

## Verification
The assertions cover the relations that must hold on every cycle. The restart strobe is one cycle wide and its code is valid. Reset and data enable are never high together. Clock generation is held off in secondary mode and during deep power-down. Every fall of the reset level comes with a cold strobe, and every new warm strobe comes out of deep power-down. Data enable rises only on a frame start that coincides with a stable bit clock. Only the directed scenarios can show which pin sequences count as each reset type. These include the short reset and SYNC pulses that are rejected, the SYNC pulse that overlaps a running clock, the effect of the disable bit, and the measured length of the restart guard.

// File: rtl/audlink_pkg.sv
package audlink_pkg;

  typedef enum logic [1:0] {
    RK_NONE     = 2'b00,
    RK_COLD     = 2'b01,
    RK_WARM     = 2'b10,
    RK_NEW_WARM = 2'b11
  } restart_kind_e;

  typedef enum logic [2:0] {
    LS_COLD,
    LS_RUN,
    LS_GUARD,
    LS_WAITCLK,
    LS_DEEP
  } link_state_e;

  // Reference-clock cycles covering a duration, rounded up.
  function automatic int ns_to_ref_cycles(input int ref_khz, input int dur_ns);
    longint prod;
    prod = longint'(ref_khz) * longint'(dur_ns);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // Counter width able to hold the value lim.
  function automatic int cnt_bits(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/audlink_sync2.sv
module audlink_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/audlink_hold_timer.sv
// Counts cycles for which hold stays high, saturating at LIMIT. The count
// survives the cycle in which hold drops, so a falling-edge decision in that
// cycle still sees the width of the pulse that just ended.
module audlink_hold_timer
  import audlink_pkg::*;
#(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic por_n,
  input  logic hold,
  output logic met
);
  localparam int CW = cnt_bits(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         cnt_q <= '0;
    else if (!hold)     cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign met = (cnt_q >= LIM);
endmodule

// File: rtl/audlink_bclk_watch.sv
// Observes the synchronized bit clock: absence after ABSENT_CYC edgeless
// cycles, stability after STABLE_EDGES consecutive rising edges.
module audlink_bclk_watch
  import audlink_pkg::*;
#(
  parameter int ABSENT_CYC   = 16,
  parameter int STABLE_EDGES = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic bclk_s,
  output logic edge_seen,
  output logic absent,
  output logic stable,
  output logic resumed
);
  localparam int IW = cnt_bits(ABSENT_CYC);
  localparam int SW = cnt_bits(STABLE_EDGES);
  localparam logic [IW-1:0] IDLE_LIM = IW'(ABSENT_CYC);
  localparam logic [SW-1:0] RUN_LIM  = SW'(STABLE_EDGES);

  logic          bclk_q;
  logic [IW-1:0] idle_q;
  logic [SW-1:0] run_q;

  assign edge_seen = bclk_s & ~bclk_q;
  assign absent    = (idle_q >= IDLE_LIM);
  assign resumed   = edge_seen & absent;
  assign stable    = !absent && (run_q >= RUN_LIM);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bclk_q <= 1'b0;
      idle_q <= IDLE_LIM;
      run_q  <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (edge_seen)    idle_q <= '0;
      else if (!absent) idle_q <= idle_q + 1'b1;

      if (edge_seen) begin
        if (absent)              run_q <= SW'(1);
        else if (run_q < RUN_LIM) run_q <= run_q + 1'b1;
      end else if (absent) begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/audlink_reset_classifier.sv
module audlink_reset_classifier
  import audlink_pkg::*;
#(
  parameter int REF_KHZ      = 24576,
  parameter int COLD_MIN_NS  = 1000,
  parameter int WARM_MIN_NS  = 1000,
  parameter int GUARD_NS     = 163,
  parameter int ABSENT_CYC   = 16,
  parameter int STABLE_EDGES = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin_n,
  input  logic       sync_in,
  input  logic       bclk_in,
  input  logic       pd_enter,
  input  logic       nwr_disable,
  input  logic       secondary_mode,
  output logic       logic_rst,
  output logic       link_restart,
  output logic [1:0] restart_kind,
  output logic       clk_gen_en,
  output logic       link_en,
  output logic       deep_pd
);
  localparam int COLD_CYC  = ns_to_ref_cycles(REF_KHZ, COLD_MIN_NS);
  localparam int WARM_CYC  = ns_to_ref_cycles(REF_KHZ, WARM_MIN_NS);
  localparam int GUARD_CYC = ns_to_ref_cycles(REF_KHZ, GUARD_NS);

  // Synchronized pins: {bit clock, SYNC, reset pin}
  logic [2:0] pins_s;
  logic       bclk_s, sync_s, rstp_s;

  audlink_sync2 #(.W(3)) u_sync (
    .clk  (clk),
    .por_n(por_n),
    .d    ({bclk_in, sync_in, rst_pin_n}),
    .q    (pins_s)
  );
  assign {bclk_s, sync_s, rstp_s} = pins_s;

  // Edge detection on the synchronized pins
  logic rstp_q, sync_q;
  logic rst_rise, sync_fall, frame_start;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rstp_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      rstp_q <= rstp_s;
      sync_q <= sync_s;
    end
  end

  assign rst_rise    = rstp_s & ~rstp_q;
  assign sync_fall   = ~sync_s & sync_q;
  assign frame_start = sync_s & ~sync_q;

  // Bit-clock observation
  logic bclk_edge, bclk_absent, bclk_stable, bclk_resumed;

  audlink_bclk_watch #(
    .ABSENT_CYC  (ABSENT_CYC),
    .STABLE_EDGES(STABLE_EDGES)
  ) u_bclk (
    .clk      (clk),
    .por_n    (por_n),
    .bclk_s   (bclk_s),
    .edge_seen(bclk_edge),
    .absent   (bclk_absent),
    .stable   (bclk_stable),
    .resumed  (bclk_resumed)
  );

  // Pulse-width qualifiers
  link_state_e state_q, state_d;
  logic rst_low_met, sync_hi_met, guard_done;

  audlink_hold_timer #(.LIMIT(COLD_CYC)) u_cold_tmr (
    .clk  (clk),
    .por_n(por_n),
    .hold (~rstp_s),
    .met  (rst_low_met)
  );

  // SYNC width only accumulates while the bit clock is absent
  audlink_hold_timer #(.LIMIT(WARM_CYC)) u_warm_tmr (
    .clk  (clk),
    .por_n(por_n),
    .hold (sync_s & bclk_absent),
    .met  (sync_hi_met)
  );

  audlink_hold_timer #(.LIMIT(GUARD_CYC)) u_guard_tmr (
    .clk  (clk),
    .por_n(por_n),
    .hold (state_q == LS_GUARD),
    .met  (guard_done)
  );

  // Event qualification
  logic cold_arm, warm_primary, warm_secondary, nwr_armed;

  assign nwr_armed      = (state_q == LS_DEEP) && !nwr_disable;
  assign cold_arm       = rst_low_met && !nwr_armed && (state_q != LS_COLD);
  assign warm_primary   = !secondary_mode && sync_fall && sync_hi_met && bclk_absent;
  assign warm_secondary = secondary_mode && bclk_resumed;

  restart_kind_e kind_d, kind_q;
  logic          strobe_q;

  always_comb begin
    state_d = state_q;
    kind_d  = RK_NONE;
    unique case (state_q)
      LS_COLD: begin
        if (rst_rise) begin
          state_d = LS_WAITCLK;
          kind_d  = RK_COLD;
        end
      end
      LS_DEEP: begin
        if (nwr_armed && rst_rise) begin
          state_d = LS_WAITCLK;
          kind_d  = RK_NEW_WARM;
        end
      end
      LS_RUN: begin
        if (pd_enter) begin
          state_d = LS_DEEP;
        end else if (warm_primary) begin
          state_d = LS_GUARD;
          kind_d  = RK_WARM;
        end else if (warm_secondary) begin
          state_d = LS_WAITCLK;
          kind_d  = RK_WARM;
        end
      end
      LS_GUARD: begin
        if (guard_done) state_d = LS_WAITCLK;
      end
      LS_WAITCLK: begin
        if (bclk_stable && frame_start) state_d = LS_RUN;
      end
      default: state_d = LS_COLD;
    endcase
    // A qualified cold reset overrides everything else
    if (cold_arm) begin
      state_d = LS_COLD;
      kind_d  = RK_NONE;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q  <= LS_COLD;
      kind_q   <= RK_NONE;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      strobe_q <= (kind_d != RK_NONE);
    end
  end

  assign logic_rst    = (state_q == LS_COLD);
  assign link_en      = (state_q == LS_RUN);
  assign deep_pd      = (state_q == LS_DEEP);
  assign clk_gen_en   = !secondary_mode &&
                        ((state_q == LS_RUN) || (state_q == LS_WAITCLK));
  assign link_restart = strobe_q;
  assign restart_kind = kind_q;
endmodule

// File: rtl/audlink_reset_classifier_chk.sv
module audlink_reset_classifier_chk (
  input logic       clk,
  input logic       por_n,
  input logic       logic_rst,
  input logic       link_restart,
  input logic [1:0] restart_kind,
  input logic       clk_gen_en,
  input logic       link_en,
  input logic       deep_pd,
  input logic       secondary_mode,
  input logic       bclk_stable,
  input logic       frame_start
);
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!por_n)
    link_restart |=> !link_restart);

  assert_rst_en_exclusive_R10: assert property (@(posedge clk) disable iff (!por_n)
    !(logic_rst && link_en));

  assert_kind_idle_R10: assert property (@(posedge clk) disable iff (!por_n)
    !link_restart |-> (restart_kind == 2'b00));

  assert_kind_valid_R2: assert property (@(posedge clk) disable iff (!por_n)
    link_restart |-> (restart_kind != 2'b00));

  assert_cold_end_strobe_R1: assert property (@(posedge clk) disable iff (!por_n)
    $fell(logic_rst) |-> (link_restart && restart_kind == 2'b01));

  assert_guard_start_R4: assert property (@(posedge clk) disable iff (!por_n)
    (link_restart && restart_kind == 2'b10 && !secondary_mode) |-> !clk_gen_en);

  assert_deep_no_gen_R5: assert property (@(posedge clk) disable iff (!por_n)
    deep_pd |-> !clk_gen_en);

  assert_new_warm_from_deep_R5: assert property (@(posedge clk) disable iff (!por_n)
    (link_restart && restart_kind == 2'b11) |-> $past(deep_pd));

  assert_secondary_no_gen_R7: assert property (@(posedge clk) disable iff (!por_n)
    secondary_mode |-> !clk_gen_en);

  assert_link_en_gate_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(link_en) |-> $past(bclk_stable && frame_start));
endmodule

bind audlink_reset_classifier audlink_reset_classifier_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .logic_rst     (logic_rst),
  .link_restart  (link_restart),
  .restart_kind  (restart_kind),
  .clk_gen_en    (clk_gen_en),
  .link_en       (link_en),
  .deep_pd       (deep_pd),
  .secondary_mode(secondary_mode),
  .bclk_stable   (bclk_stable),
  .frame_start   (frame_start)
);

// File: tb/sim_audlink_reset_classifier.sv
`timescale 1ns/1ps
module sim_audlink_reset_classifier;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       bclk_in = 1'b0;
  logic       pd_enter = 1'b0;
  logic       nwr_disable = 1'b0;
  logic       secondary_mode = 1'b0;
  logic       logic_rst, link_restart, clk_gen_en, link_en, deep_pd;
  logic [1:0] restart_kind;

  always #10 clk = ~clk;  // 50 MHz

  audlink_reset_classifier u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .sync_in(sync_in),
    .bclk_in(bclk_in), .pd_enter(pd_enter), .nwr_disable(nwr_disable),
    .secondary_mode(secondary_mode), .logic_rst(logic_rst),
    .link_restart(link_restart), .restart_kind(restart_kind),
    .clk_gen_en(clk_gen_en), .link_en(link_en), .deep_pd(deep_pd)
  );

  // Expected cycle counts, derived from the 24.576 MHz reference by rounding up
  int exp_guard;
  initial begin
    exp_guard = (24576 * 163) / 1000000;
    if (exp_guard * 1000000 < 24576 * 163) exp_guard++;
  end

  int total = 0;
  int fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input bit cond, input int act, input int exp);
    total++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Port monitor
  int  evt_cnt = 0;
  int  last_kind = 0;
  int  wide_strobes = 0;
  int  both_high = 0;
  bit  rst_seen = 0;
  bit  gen_seen = 0;
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (por_n) begin
        if (link_restart) begin
          evt_cnt++;
          last_kind = int'(restart_kind);
          if (prev) wide_strobes++;
        end else if (restart_kind != 2'b00) begin
          wide_strobes++;
        end
        if (logic_rst && link_en) both_high++;
        if (logic_rst) rst_seen = 1;
        if (clk_gen_en) gen_seen = 1;
        prev = link_restart;
      end
    end
  end

  // Bit-clock source: period of six reference cycles when enabled
  bit bclk_on = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (bclk_on) begin
        bclk_in = 1'b1;
        repeat (3) @(negedge clk);
        bclk_in = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        bclk_in = 1'b0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1; idle(4);
      sync_in = 1'b0; idle(36);
    end
  endtask

  task automatic pin_low(input int n);
    rst_pin_n = 1'b0; idle(n);
    rst_pin_n = 1'b1;
  endtask

  task automatic t_power_on;
    idle(1);
    chk("R9 logic_rst after por", logic_rst, 1);
    chk("R9 link_en after por", link_en, 0);
    idle(10);
    chk("R9 logic_rst held while pin low", logic_rst, 1);
    rst_pin_n = 1'b1; idle(6);
    chk("R9 one event on release", evt_cnt, 1);
    chk("R9 release kind cold", last_kind, 1);
    chk("R9 logic_rst released", logic_rst, 0);
    bclk_on = 1; idle(12);
    sync_in = 1'b1; idle(4); sync_in = 1'b0; idle(6);
    chk("R8 link_en held before clock stable", link_en, 0);
    frames(4);
    chk("R8 link_en after stable clock and frame", link_en, 1);
  endtask

  task automatic t_short_cold;
    int e0 = evt_cnt;
    rst_seen = 0;
    pin_low(10); idle(8);
    chk("R1 short low: no event", evt_cnt - e0, 0);
    chk("R1 short low: no logic_rst", int'(rst_seen), 0);
    chk("R1 short low: link_en kept", link_en, 1);
  endtask

  task automatic t_cold;
    int e0 = evt_cnt;
    rst_pin_n = 1'b0; idle(40);
    chk("R1 logic_rst during long low", logic_rst, 1);
    chk("R1 link_en off during cold", link_en, 0);
    rst_pin_n = 1'b1; idle(6);
    chk("R1 cold event count", evt_cnt - e0, 1);
    chk("R1 cold kind", last_kind, 1);
    chk("R1 logic_rst dropped", logic_rst, 0);
    frames(4);
    chk("R8 link_en back after cold", link_en, 1);
  endtask

  task automatic t_sync_ignored;
    int e0 = evt_cnt;
    sync_in = 1'b1; idle(40); sync_in = 1'b0; idle(10);
    chk("R3 long SYNC with clock running: no event", evt_cnt - e0, 0);
    chk("R3 link_en kept", link_en, 1);
  endtask

  task automatic t_warm;
    int e0;
    int low_len = 0;
    int waited = 0;
    bclk_on = 0; idle(30);
    e0 = evt_cnt;
    sync_in = 1'b1; idle(10); sync_in = 1'b0; idle(10);
    chk("R3 short SYNC with clock absent: no event", evt_cnt - e0, 0);
    rst_seen = 0;
    sync_in = 1'b1; idle(40); sync_in = 1'b0;
    while (clk_gen_en && waited < 20) begin idle(1); waited++; end
    chk("R2 warm event count", evt_cnt - e0, 1);
    chk("R2 warm kind", last_kind, 2);
    chk("R2 link_en cleared", link_en, 0);
    while (!clk_gen_en && low_len < 50) begin idle(1); low_len++; end
    chk_true("R4 guard at least GUARD_CYC", low_len >= exp_guard, low_len, exp_guard);
    chk_true("R4 guard bounded", low_len <= exp_guard + 3, low_len, exp_guard + 3);
    chk("R2 no logic_rst on warm", int'(rst_seen), 0);
    bclk_on = 1; frames(4);
    chk("R8 link_en after warm", link_en, 1);
  endtask

  task automatic t_new_warm;
    int e0 = evt_cnt;
    pd_enter = 1'b1; idle(1); pd_enter = 1'b0; idle(2);
    chk("R5 deep_pd set", deep_pd, 1);
    chk("R5 link_en off in deep", link_en, 0);
    chk("R5 clk_gen_en off in deep", clk_gen_en, 0);
    rst_seen = 0;
    pin_low(40); idle(6);
    chk("R5 new warm event", evt_cnt - e0, 1);
    chk("R5 new warm kind", last_kind, 3);
    chk("R5 no logic_rst", int'(rst_seen), 0);
    chk("R5 deep_pd cleared", deep_pd, 0);
    frames(4);
    chk("R8 link_en after new warm", link_en, 1);
  endtask

  task automatic t_nwr_disabled;
    int e0 = evt_cnt;
    nwr_disable = 1'b1;
    pd_enter = 1'b1; idle(1); pd_enter = 1'b0; idle(2);
    chk("R6 deep_pd set", deep_pd, 1);
    rst_pin_n = 1'b0; idle(40);
    chk("R6 logic_rst with detection off", logic_rst, 1);
    rst_pin_n = 1'b1; idle(6);
    chk("R6 event count", evt_cnt - e0, 1);
    chk("R6 kind cold", last_kind, 1);
    nwr_disable = 1'b0;
    frames(4);
    chk("R8 link_en after disabled-path cold", link_en, 1);
  endtask

  task automatic t_secondary;
    int e0;
    secondary_mode = 1'b1; idle(2);
    gen_seen = 0;
    chk("R7 clk_gen_en off in secondary", clk_gen_en, 0);
    bclk_on = 0; idle(30);
    e0 = evt_cnt;
    sync_in = 1'b1; idle(40); sync_in = 1'b0; idle(10);
    chk("R7 SYNC ignored in secondary", evt_cnt - e0, 0);
    chk("R7 link_en kept", link_en, 1);
    bclk_on = 1; idle(8);
    chk("R7 resume event", evt_cnt - e0, 1);
    chk("R7 resume kind warm", last_kind, 2);
    chk("R7 link_en cleared", link_en, 0);
    frames(4);
    chk("R8 link_en after secondary warm", link_en, 1);
    chk("R7 clk_gen_en never high", int'(gen_seen), 0);
    secondary_mode = 1'b0;
  endtask

  initial begin
    idle(5);
    por_n = 1'b1;
    t_power_on();
    t_short_cold();
    t_cold();
    t_sync_ignored();
    t_warm();
    t_new_warm();
    t_nwr_disabled();
    t_secondary();
    chk("R10 strobe width and idle code", wide_strobes, 0);
    chk("R10 logic_rst and link_en exclusive", both_high, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule